// File: doc/BRIEF.md
# Video Timing Auto-Sizing Measurement

This block watches horizontal and vertical flyback pulses together with three video-present inputs. Over one whole frame it finds where active picture content lies. Horizontal positions are counted in pixel clocks from the leading edge of the horizontal pulse. Vertical positions are counted in lines from the leading edge of the vertical pulse, with the horizontal pulse serving as the line clock. A controller reads the results and adjusts picture size and centring until the front and back porches balance.

Measurement is armed by setting an enable bit. It starts on the first vertical leading edge after that and ends on the next one. The results are the smallest horizontal start, the largest horizontal end, the first and last active line, and the total line count for the frame. They are packed into a ten-byte read-only bank, and a done flag is raised. The bank stays frozen until the enable bit is cleared and set again. Each measured input has its own polarity select. All inputs pass through two-flop synchronisers before use.

Top module: `vsm_meter`

## Requirements
- R1: The horizontal start result is the smallest pixel position, over the measured frame, at which video is active. Position 0 is the clock in which the polarity-corrected horizontal leading edge is seen, and the position rises by one on each later pixel clock.
- R2: The horizontal end result is the largest pixel position, over the measured frame, at which video is active.
- R3: The vertical start and end results are the smallest and largest line numbers holding active video. Line 0 begins at the vertical leading edge, and each later horizontal leading edge adds one.
- R4: The total result equals the number of horizontal leading edges between the opening and closing vertical leading edges.
- R5: Measurement begins only at the first vertical leading edge after `meas_en` is set. Video seen before that edge has no effect on the results.
- R6: `meas_done` rises once the closing vertical edge is seen. While `meas_en` stays high, `meas_done` and the result bank remain frozen, even across further frames. Clearing `meas_en` drops `meas_done` in the next cycle.
- R7: If the 11-bit line counter wraps past 2047 during the measured frame, the overflow flag is set and the total holds the wrapped count.
- R8: Each of the horizontal, vertical, red, green and blue inputs has a polarity select, where 1 means active high and 0 means active low. Video counts as active when any corrected colour input is active.
- R9: If no video is active during the measured frame, the start results read all ones (0x3FF and 0x7FF) and the end results read zero.
- R10: The byte layout is as follows, with byte k at `meas_bytes[8k+7:8k]`:
  - Bytes 0 and 1 hold the horizontal start, with its bits 9:8 in byte 0 bits 1:0.
  - Bytes 2 and 3 hold the horizontal end in the same way.
  - Bytes 4 and 5 hold the vertical start, with its bits 10:8 in byte 4 bits 2:0.
  - Bytes 6 and 7 hold the vertical end in the same way.
  - Byte 8 holds the overflow flag in bit 3 and total bits 10:8 in bits 2:0.
  - Byte 9 holds total bits 7:0.
  - All other bits read zero.
- R11: After reset, `meas_done` is low, the starts read all ones, and the ends, total and overflow read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Horizontal flyback pulse |
| vs_in | input | 1 | Vertical flyback pulse |
| red_in | input | 1 | Red video-present input |
| grn_in | input | 1 | Green video-present input |
| blu_in | input | 1 | Blue video-present input |
| hs_pol | input | 1 | Horizontal polarity (1 = active high) |
| vs_pol | input | 1 | Vertical polarity (1 = active high) |
| vid_pol | input | 3 | Colour polarities {blue, green, red} |
| meas_en | input | 1 | Arm measurement |
| meas_done | output | 1 | Frame measured, results frozen |
| meas_bytes | output | 80 | Ten-byte result bank |

## Verification
A wrong pixel counter or line counter shows up one frame later as shifted start and end values. Because the bench never places video at position 0, a one-off error in the counter reset point appears directly as an off-by-one in the bytes. A state machine that restarts on later vertical edges is caught when a wide-video frame driven after done changes the frozen bank. A lost arm or done transition shows on `meas_done` within one line. Polarity faults turn a planned frame into a no-video or full-line result.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2,
    ST_DONE  = 2'd3
  } meas_st_t;

  localparam int RES_BYTES = 10;
endpackage

// File: rtl/vsm_sync.sv
// Synchroniser followed by polarity correction; output is active-high level.
module vsm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic level
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level = pol ? sh_q[STAGES-1] : ~sh_q[STAGES-1];
endmodule

// File: rtl/vsm_hpos.sv
// Pixel position within a line: 0 in the edge clock, saturating upward.
module vsm_hpos #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hedge,
  output logic [W-1:0] pos
);
  localparam logic [W-1:0] POS_MAX = '1;
  logic [W-1:0] pos_q;

  always_comb begin
    if (hedge)                pos = '0;
    else if (pos_q == POS_MAX) pos = pos_q;
    else                       pos = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= POS_MAX;
    else        pos_q <= pos;
  end
endmodule

// File: rtl/vsm_extreme.sv
// Running minimum and maximum of a value under an update enable.
module vsm_extreme #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         upd,
  input  logic [W-1:0] val,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [W-1:0] lo_d, hi_d;
  logic         lo_en, hi_en;

  always_comb begin
    lo_en = clr | (upd & (val < lo));
    hi_en = clr | (upd & (val > hi));
    lo_d  = clr ? '1 : val;
    hi_d  = clr ? '0 : val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '1;
      hi <= '0;
    end else begin
      if (lo_en) lo <= lo_d;
      if (hi_en) hi <= hi_d;
    end
  end
endmodule

// File: rtl/vsm_meter.sv
module vsm_meter #(
  parameter int H_W    = 10,
  parameter int V_W    = 11,
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hs_in,
  input  logic        vs_in,
  input  logic        red_in,
  input  logic        grn_in,
  input  logic        blu_in,
  input  logic        hs_pol,
  input  logic        vs_pol,
  input  logic [2:0]  vid_pol,
  input  logic        meas_en,
  output logic        meas_done,
  output logic [79:0] meas_bytes
);
  import vsm_pkg::*;

  localparam int NIN = 5;

  logic [NIN-1:0] pins, pols, lvl;
  logic [1:0]     prev_q, rise;
  logic           hedge, vedge, vid_act;

  assign pins = {blu_in, grn_in, red_in, vs_in, hs_in};
  assign pols = {vid_pol, vs_pol, hs_pol};

  for (genvar gi = 0; gi < NIN; gi++) begin : g_in
    vsm_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pins[gi]), .pol(pols[gi]), .level(lvl[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= lvl[1:0];
  end

  assign rise    = lvl[1:0] & ~prev_q;
  assign hedge   = rise[0];
  assign vedge   = rise[1];
  assign vid_act = |lvl[4:2];

  // Pixel position
  logic [H_W-1:0] hpos;
  vsm_hpos #(.W(H_W)) u_hpos (.clk(clk), .rst_n(rst_n), .hedge(hedge), .pos(hpos));

  // Line counter (wraps)
  logic [V_W-1:0] vcnt_q, vcnt_d;
  logic           vwrap;
  always_comb begin
    vwrap = hedge & ~vedge & (&vcnt_q);
    if (vedge)      vcnt_d = '0;
    else if (hedge) vcnt_d = vcnt_q + 1'b1;
    else            vcnt_d = vcnt_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcnt_q <= '0;
    else        vcnt_q <= vcnt_d;
  end

  // Control
  meas_st_t st_q, st_d;
  logic     start, fin, upd;
  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    fin   = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (meas_en) st_d = ST_ARMED;
      ST_ARMED: if (!meas_en) st_d = ST_IDLE;
                else if (vedge) begin st_d = ST_MEAS; start = 1'b1; end
      ST_MEAS:  if (!meas_en) st_d = ST_IDLE;
                else if (vedge) begin st_d = ST_DONE; fin = 1'b1; end
      ST_DONE:  if (!meas_en) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    upd = (st_q == ST_MEAS) & meas_en & ~vedge & vid_act;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // Extremes
  logic [H_W-1:0] h_lo, h_hi;
  logic [V_W-1:0] v_lo, v_hi;
  vsm_extreme #(.W(H_W)) u_hx (.clk(clk), .rst_n(rst_n), .clr(start), .upd(upd),
                               .val(hpos), .lo(h_lo), .hi(h_hi));
  vsm_extreme #(.W(V_W)) u_vx (.clk(clk), .rst_n(rst_n), .clr(start), .upd(upd),
                               .val(vcnt_d), .lo(v_lo), .hi(v_hi));

  // Total and overflow
  logic [V_W-1:0] tot_q;
  logic           ovf_q, ovf_en, tot_en;
  always_comb begin
    ovf_en = start | ((st_q == ST_MEAS) & meas_en & vwrap);
    tot_en = start | fin;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (tot_en) tot_q <= start ? '0 : vcnt_q;
      if (ovf_en) ovf_q <= ~start;
    end
  end

  assign meas_done = (st_q == ST_DONE);

  // Byte packing
  logic [15:0] hs16, he16, vs16, ve16, vt16;
  assign hs16 = 16'(h_lo);
  assign he16 = 16'(h_hi);
  assign vs16 = 16'(v_lo);
  assign ve16 = 16'(v_hi);
  assign vt16 = 16'(tot_q);

  assign meas_bytes = {vt16[7:0], vt16[15:8] | (8'(ovf_q) << (V_W - 8)),
                       ve16[7:0], ve16[15:8], vs16[7:0], vs16[15:8],
                       he16[7:0], he16[15:8], hs16[7:0], hs16[15:8]};
endmodule

// File: rtl/vsm_meter_chk.sv
module vsm_meter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        meas_en,
  input logic        meas_done,
  input logic [79:0] meas_bytes
);
  logic [9:0]  hs_v, he_v;
  logic [10:0] vs_v, ve_v;
  assign hs_v = {meas_bytes[1:0],   meas_bytes[15:8]};
  assign he_v = {meas_bytes[17:16], meas_bytes[31:24]};
  assign vs_v = {meas_bytes[34:32], meas_bytes[47:40]};
  assign ve_v = {meas_bytes[50:48], meas_bytes[63:56]};

  // R6
  done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && meas_en) |=> (meas_done && $stable(meas_bytes)));
  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> !meas_done);
  // R5
  done_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_done) |-> $past(meas_en));
  // R10
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_bytes[7:2] == 6'd0) && (meas_bytes[23:18] == 6'd0) &&
    (meas_bytes[39:35] == 5'd0) && (meas_bytes[55:51] == 5'd0) &&
    (meas_bytes[71:68] == 4'd0));
  // R1
  h_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> ((hs_v == 10'h3FF && he_v == 10'd0) || (hs_v <= he_v)));
  // R3
  v_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> ((vs_v == 11'h7FF && ve_v == 11'd0) || (vs_v <= ve_v)));
endmodule

bind vsm_meter vsm_meter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .meas_en(meas_en),
  .meas_done(meas_done), .meas_bytes(meas_bytes)
);

// File: tb/sim_vsm_meter.sv
`timescale 1ns/1ps
module sim_vsm_meter;
  logic clk = 1'b0;
  logic rst_n;
  logic hs_in, vs_in, red_in, grn_in, blu_in;
  logic hs_pol, vs_pol;
  logic [2:0] vid_pol;
  logic meas_en;
  logic meas_done;
  logic [79:0] meas_bytes;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vsm_meter u0 (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
    .red_in(red_in), .grn_in(grn_in), .blu_in(blu_in),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .vid_pol(vid_pol),
    .meas_en(meas_en), .meas_done(meas_done), .meas_bytes(meas_bytes)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [79:0] pack(input logic [9:0] hs, input logic [9:0] he,
                                       input logic [10:0] vs, input logic [10:0] ve,
                                       input logic [10:0] tot, input logic ovf);
    return {tot[7:0], {4'd0, ovf, tot[10:8]}, ve[7:0], {5'd0, ve[10:8]},
            vs[7:0], {5'd0, vs[10:8]}, he[7:0], {6'd0, he[9:8]},
            hs[7:0], {6'd0, hs[9:8]}};
  endfunction

  task automatic chk(input string req, input logic [79:0] got, input logic [79:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_res(input string tag, input logic [9:0] hs, input logic [9:0] he,
                         input logic [10:0] vs, input logic [10:0] ve,
                         input logic [10:0] tot, input logic ovf);
    chk({tag, " R1 hstart"}, 80'({meas_bytes[1:0], meas_bytes[15:8]}), 80'(hs));
    chk({tag, " R2 hend"}, 80'({meas_bytes[17:16], meas_bytes[31:24]}), 80'(he));
    chk({tag, " R3 vstart"}, 80'({meas_bytes[34:32], meas_bytes[47:40]}), 80'(vs));
    chk({tag, " R3 vend"}, 80'({meas_bytes[50:48], meas_bytes[63:56]}), 80'(ve));
    chk({tag, " R4 total"}, 80'({meas_bytes[66:64], meas_bytes[79:72]}), 80'(tot));
    chk({tag, " R7 ovf"}, 80'(meas_bytes[67]), 80'(ovf));
    chk({tag, " R10 layout"}, meas_bytes, pack(hs, he, vs, ve, tot, ovf));
  endtask

  // One line of L clocks; hsync active 0..3, vsync active mid-line if vsr,
  // colour channels in chm active for positions a..b if act.
  task automatic line(input int L, input bit vsr, input bit act, input int a,
                      input int b, input logic [2:0] chm);
    for (int c = 0; c < L; c++) begin
      @(negedge clk);
      hs_in = (c < 4) ? hs_pol : ~hs_pol;
      vs_in = (vsr && c >= L/2 && c < L/2 + 4) ? vs_pol : ~vs_pol;
      red_in = (act && chm[0] && c >= a && c <= b) ? vid_pol[0] : ~vid_pol[0];
      grn_in = (act && chm[1] && c >= a && c <= b) ? vid_pol[1] : ~vid_pol[1];
      blu_in = (act && chm[2] && c >= a && c <= b) ? vid_pol[2] : ~vid_pol[2];
    end
  endtask

  task automatic quiet(input int L, input int n);
    for (int i = 0; i < n; i++) line(L, 1'b0, 1'b0, 0, 0, 3'b000);
  endtask

  task automatic rearm(input int L);
    @(negedge clk); meas_en = 1'b0;
    quiet(L, 1);
    chk("R6 done clears with enable", 80'(meas_done), 80'd0);
    meas_en = 1'b1;
    quiet(L, 1);
    chk("R5 armed, not done", 80'(meas_done), 80'd0);
  endtask

  task automatic t_reset();
    chk("R11 done after reset", 80'(meas_done), 80'd0);
    chk_res("R11 R9 reset", 10'h3FF, 10'd0, 11'h7FF, 11'd0, 11'd0, 1'b0);
  endtask

  task automatic t_basic();
    meas_en = 1'b1;
    quiet(40, 1);
    line(40, 1'b0, 1'b1, 2, 38, 3'b001);   // R5: before opening edge, ignored
    line(40, 1'b1, 1'b0, 0, 0, 3'b000);    // opening edge, line 0
    for (int k = 1; k < 10; k++) begin
      case (k)
        3: line(40, 1'b0, 1'b1, 12, 20, 3'b001);
        4: line(40, 1'b0, 1'b1, 10, 25, 3'b010);
        5: line(40, 1'b0, 1'b1, 15, 30, 3'b100);
        6: line(40, 1'b0, 1'b1, 11, 22, 3'b011);
        default: line(40, 1'b0, 1'b0, 0, 0, 3'b000);
      endcase
      if (k == 5) chk("R6 not done mid frame", 80'(meas_done), 80'd0);
    end
    line(40, 1'b1, 1'b0, 0, 0, 3'b000);    // closing edge
    quiet(40, 2);
    chk("R6 done after frame", 80'(meas_done), 80'd1);
    chk_res("basic", 10'd10, 10'd30, 11'd3, 11'd6, 11'd10, 1'b0);
  endtask

  task automatic t_frozen();
    for (int f = 0; f < 2; f++) begin
      line(40, 1'b1, 1'b1, 1, 39, 3'b111);
      for (int k = 1; k < 4; k++) line(40, 1'b0, 1'b1, 1, 39, 3'b111);
    end
    quiet(40, 2);
    chk("R6 done held", 80'(meas_done), 80'd1);
    chk_res("R6 frozen", 10'd10, 10'd30, 11'd3, 11'd6, 11'd10, 1'b0);
  endtask

  task automatic t_polarity();
    @(negedge clk); meas_en = 1'b0;
    hs_pol = 1'b0; vs_pol = 1'b0; vid_pol = 3'b101;  // R8: green active low
    quiet(30, 2);
    rearm(30);
    line(30, 1'b0, 1'b1, 1, 28, 3'b010);
    line(30, 1'b1, 1'b0, 0, 0, 3'b000);
    for (int k = 1; k < 6; k++) begin
      if (k == 2)      line(30, 1'b0, 1'b1, 5, 9, 3'b010);
      else if (k == 4) line(30, 1'b0, 1'b1, 7, 27, 3'b010);
      else             line(30, 1'b0, 1'b0, 0, 0, 3'b000);
    end
    line(30, 1'b1, 1'b0, 0, 0, 3'b000);
    quiet(30, 2);
    chk("R8 done", 80'(meas_done), 80'd1);
    chk_res("R8 polarity", 10'd5, 10'd27, 11'd2, 11'd4, 11'd6, 1'b0);
  endtask

  task automatic t_novideo();
    rearm(20);
    line(20, 1'b1, 1'b0, 0, 0, 3'b000);
    quiet(20, 4);
    line(20, 1'b1, 1'b0, 0, 0, 3'b000);
    quiet(20, 2);
    chk_res("R9 no video", 10'h3FF, 10'd0, 11'h7FF, 11'd0, 11'd5, 1'b0);
  endtask

  task automatic t_overflow();
    rearm(8);
    line(8, 1'b1, 1'b0, 0, 0, 3'b000);
    quiet(8, 2099);
    line(8, 1'b1, 1'b0, 0, 0, 3'b000);
    quiet(8, 3);
    chk("R7 done", 80'(meas_done), 80'd1);
    chk_res("R7 wrap", 10'h3FF, 10'd0, 11'h7FF, 11'd0, 11'd52, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; meas_en = 1'b0;
    hs_pol = 1'b1; vs_pol = 1'b1; vid_pol = 3'b111;
    hs_in = 1'b0; vs_in = 1'b0; red_in = 1'b0; grn_in = 1'b0; blu_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_frozen();
    t_polarity();
    t_novideo();
    t_overflow();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule